// File: doc/BRIEF.md
# Two-Wire Bus Controller Host Register Block

This block is the processor-facing side of a two-wire serial bus controller. It holds the controller's own-address register, data register, control register and status register. A host reaches them over a bidirectional 8-bit data bus. Each register has its own active-low select line, so registers are picked by one-hot selects rather than by an address.

A protocol engine sits beside the block and is not part of it. The engine loads status codes and shifted data bytes through single-cycle strobes. It raises the interrupt flag and may ask for the stop-request bit to be dropped. It also supplies an internal-status byte that the host can read.

The block presents the control bits to the engine: enable, start, stop, acknowledge and the three baud-select bits. It also derives one helper baud signal from two of those bits. The interrupt request output follows the interrupt flag. The engine can set that flag, but only the host can clear it, and only while a separate clear-enable input is high.

Top module: `i2c_host_regs`

## Requirements
- R1: A synchronous active-low reset leaves the status register reading F8h and the address, data and control registers reading 00h, with the interrupt request low.
- R2: Writes are captured on the falling clock edge when `rd_en` and `bus_en` are both low. The write selects are active low: bit 2 selects address, bit 1 selects data and bit 0 selects control. Every low select loads the same byte. A write presented while `rd_en` or `bus_en` is high changes nothing.
- R3: When both `rd_en` and `bus_en` are high, a low read select drives the bus with a register. Bit 4 selects internal status, bit 3 status, bit 2 address, bit 1 data and bit 0 control. With no read select low, or with either enable low, the bus is left high-impedance.
- R4: A pulse on `eng_si_set` sets the interrupt flag (control bit 3), and `irq` is high exactly while that flag is 1.
- R5: A host control write clears the interrupt flag only when the written bit 3 is 0 and `clr_en` is 1. With `clr_en` at 0 the flag keeps its value. A host write never sets the flag.
- R6: A pulse on `eng_stat_ld` loads the 5-bit `eng_stat_code` into status bits 7:3, and status bits 2:0 always read 0.
- R7: The address register presents bits 7:1 on `own_addr` and bit 0 on `gc_en`.
- R8: `eng_sto_clr` clears the stop-request bit (control bit 4). A host control write in the same cycle takes precedence.
- R9: Control bits, from MSB down, are: baud bit 2, enable, start, stop, interrupt flag, acknowledge, baud bit 1 and baud bit 0. They drive `baud_sel`, `ena`, `start_req`, `stop_req` and `ack_en`. The output `baud_mix` equals baud bit 1 OR NOT baud bit 0.
- R10: When the engine sets the interrupt flag in the same cycle that the host clears it, the flag ends up set.
- R11: When an engine data load and a host data write fall in the same cycle, the engine byte is stored. The data register is presented on `dat_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; registers update on its falling edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_sel_n | input | 5 | Active-low one-hot read selects |
| wr_sel_n | input | 3 | Active-low write selects |
| rd_en | input | 1 | Read enable; low for a write |
| bus_en | input | 1 | Bus enable; high lets the block drive the bus |
| clr_en | input | 1 | Permits the host to clear the interrupt flag |
| data_io | inout | 8 | Bidirectional host data bus |
| irq | output | 1 | Interrupt request, high while the flag is set |
| eng_stat_ld | input | 1 | Engine strobe loading a status code |
| eng_stat_code | input | 5 | Status code from the engine |
| eng_si_set | input | 1 | Engine strobe setting the interrupt flag |
| eng_dat_ld | input | 1 | Engine strobe loading the data register |
| eng_dat_in | input | 8 | Byte from the engine shifter |
| eng_sto_clr | input | 1 | Engine request to drop the stop bit |
| eng_ist | input | 8 | Internal-status byte from the engine |
| own_addr | output | 7 | Own bus address |
| gc_en | output | 1 | General-call recognition enable |
| dat_q | output | 8 | Data register contents |
| ena | output | 1 | Controller enable bit |
| start_req | output | 1 | Start request bit |
| stop_req | output | 1 | Stop request bit |
| ack_en | output | 1 | Acknowledge enable bit |
| baud_sel | output | 3 | Baud-select bits {2,1,0} |
| baud_mix | output | 1 | Baud bit 1 OR NOT baud bit 0 |

## Verification
Two pairs of events can land on the same falling edge: the engine setting the interrupt flag while the host clears it, and the engine dropping the stop bit while the host rewrites it. The bench provokes both by raising the engine strobe and the host control write inside one step. It then judges the result at the `irq` and `stop_req` pins one cycle later: the flag must remain set and the host's stop value must remain. A third collision, an engine data load against a host data write, is judged by reading the data register back over the bus.

// File: rtl/i2c_host_pkg.sv
// Package: shared widths, select indices and control bit positions for the
// host register block. Assumes an 8-bit host bus and a 5-bit status code.
package i2c_host_pkg;
    localparam int BYTE_W = 8;
    localparam int CODE_W = 5;
    localparam int N_RD   = 5;
    localparam int N_WR   = 3;

    // read select indices
    localparam int RD_CTL = 0;
    localparam int RD_DAT = 1;
    localparam int RD_ADR = 2;
    localparam int RD_STA = 3;
    localparam int RD_IST = 4;

    // write select indices
    localparam int WR_CTL = 0;
    localparam int WR_DAT = 1;
    localparam int WR_ADR = 2;

    // control bit positions (order is visible to software)
    localparam int CB_CR0 = 0;
    localparam int CB_CR1 = 1;
    localparam int CB_ACK = 2;
    localparam int CB_SI  = 3;
    localparam int CB_STO = 4;
    localparam int CB_STA = 5;
    localparam int CB_ENA = 6;
    localparam int CB_CR2 = 7;

    // status code meaning "nothing to report", used at reset
    localparam logic [CODE_W-1:0] CODE_IDLE = 5'h1F;
endpackage

// File: rtl/i2c_host_byte_reg.sv
// Module: generic register with a host write port and an engine load port.
// Assumes single-cycle strobes. The engine load wins over a host write in the
// same cycle. Updates on the falling clock edge, synchronous active-low reset.
module i2c_host_byte_reg #(
    parameter int          W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         host_we,
    input  logic [W-1:0] host_d,
    input  logic         eng_ld,
    input  logic [W-1:0] eng_d,
    output logic [W-1:0] q
);
    // hold the value; the engine takes priority over the host
    always_ff @(negedge clk) begin
        if (!rst_n)       q <= RST_VAL;
        else if (eng_ld)  q <= eng_d;
        else if (host_we) q <= host_d;
    end
endmodule

// File: rtl/i2c_host_ctl_reg.sv
// Module: control register with interrupt-flag and stop-bit rules.
// Assumes the package bit positions. A host write cannot set the flag and clears
// it only with clr_en. An engine set wins over a host clear. A host stop write
// wins over an engine stop clear.
module i2c_host_ctl_reg
    import i2c_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [BYTE_W-1:0] host_d,
    input  logic              clr_en,
    input  logic              si_set,
    input  logic              sto_clr,
    output logic [BYTE_W-1:0] q
);
    logic si_nxt;
    logic sto_nxt;

    // next interrupt flag: engine set first, then a permitted host clear
    always_comb begin
        si_nxt = q[CB_SI];
        if (host_we && clr_en && !host_d[CB_SI]) si_nxt = 1'b0;
        if (si_set) si_nxt = 1'b1;
    end

    // next stop bit: a host write overrides an engine clear
    always_comb begin
        sto_nxt = q[CB_STO];
        if (sto_clr) sto_nxt = 1'b0;
        if (host_we) sto_nxt = host_d[CB_STO];
    end

    // register update with the special bits merged in
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            if (host_we) q <= host_d;
            q[CB_SI]  <= si_nxt;
            q[CB_STO] <= sto_nxt;
        end
    end
endmodule

// File: rtl/i2c_host_rd_mux.sv
// Module: read multiplexer for one-hot active-low selects. Assumes at most one
// select is low; if several are, their sources are ORed together. It asserts
// drive only when a select is low and both enables are high.
module i2c_host_rd_mux #(
    parameter int W = 8,
    parameter int N = 5
) (
    input  logic [N-1:0]        sel_n,
    input  logic [N-1:0][W-1:0] src,
    input  logic                rd_en,
    input  logic                bus_en,
    output logic                drive,
    output logic [W-1:0]        rdata
);
    logic [N-1:0][W-1:0] masked;

    // gate each source by its select
    for (genvar i = 0; i < N; i++) begin : g_mask
        assign masked[i] = sel_n[i] ? '0 : src[i];
    end

    // combine gated sources
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N; i++) rdata = rdata | masked[i];
    end

    // drive the bus only during a qualified read
    assign drive = rd_en && bus_en && !(&sel_n);
endmodule

// File: rtl/i2c_host_regs.sv
// Module: top of the host register block. It decodes the one-hot selects,
// holds the four registers, drives the tri-state bus and exports the control
// bits. Assumes the engine pulses its strobes for one clock. Updates happen on
// the falling clock edge.
module i2c_host_regs
    import i2c_host_pkg::*;
#(
    parameter int DATA_W = BYTE_W,
    parameter int STAT_W = CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_RD-1:0]   rd_sel_n,
    input  logic [N_WR-1:0]   wr_sel_n,
    input  logic              rd_en,
    input  logic              bus_en,
    input  logic              clr_en,
    inout  wire  [DATA_W-1:0] data_io,
    output logic              irq,
    input  logic              eng_stat_ld,
    input  logic [STAT_W-1:0] eng_stat_code,
    input  logic              eng_si_set,
    input  logic              eng_dat_ld,
    input  logic [DATA_W-1:0] eng_dat_in,
    input  logic              eng_sto_clr,
    input  logic [DATA_W-1:0] eng_ist,
    output logic [DATA_W-2:0] own_addr,
    output logic              gc_en,
    output logic [DATA_W-1:0] dat_q,
    output logic              ena,
    output logic              start_req,
    output logic              stop_req,
    output logic              ack_en,
    output logic [2:0]        baud_sel,
    output logic              baud_mix
);
    localparam int PAD_W = DATA_W - STAT_W;

    logic                        wr_ok;
    logic [N_WR-1:0]             we;
    logic [DATA_W-1:0]           adr_q;
    logic [DATA_W-1:0]           ctl_q;
    logic [STAT_W-1:0]           stat_q;
    logic [N_RD-1:0][DATA_W-1:0] rd_src;
    logic                        drive;
    logic [DATA_W-1:0]           rdata;

    // write qualification: both enables low
    assign wr_ok = !rd_en && !bus_en;

    // per-register write strobes
    for (genvar i = 0; i < N_WR; i++) begin : g_we
        assign we[i] = wr_ok && !wr_sel_n[i];
    end

    // address register
    i2c_host_byte_reg #(.W(DATA_W), .RST_VAL('0)) u_adr (
        .clk(clk), .rst_n(rst_n), .host_we(we[WR_ADR]), .host_d(data_io),
        .eng_ld(1'b0), .eng_d('0), .q(adr_q)
    );

    // data register, loaded by the host or the engine shifter
    i2c_host_byte_reg #(.W(DATA_W), .RST_VAL('0)) u_dat (
        .clk(clk), .rst_n(rst_n), .host_we(we[WR_DAT]), .host_d(data_io),
        .eng_ld(eng_dat_ld), .eng_d(eng_dat_in), .q(dat_q)
    );

    // status code, engine-loaded only
    i2c_host_byte_reg #(.W(STAT_W), .RST_VAL(CODE_IDLE)) u_sta (
        .clk(clk), .rst_n(rst_n), .host_we(1'b0), .host_d('0),
        .eng_ld(eng_stat_ld), .eng_d(eng_stat_code), .q(stat_q)
    );

    // control register with flag rules
    i2c_host_ctl_reg u_ctl (
        .clk(clk), .rst_n(rst_n), .host_we(we[WR_CTL]), .host_d(data_io),
        .clr_en(clr_en), .si_set(eng_si_set), .sto_clr(eng_sto_clr), .q(ctl_q)
    );

    // read sources in select order
    assign rd_src[RD_CTL] = ctl_q;
    assign rd_src[RD_DAT] = dat_q;
    assign rd_src[RD_ADR] = adr_q;
    assign rd_src[RD_STA] = {stat_q, {PAD_W{1'b0}}};
    assign rd_src[RD_IST] = eng_ist;

    i2c_host_rd_mux #(.W(DATA_W), .N(N_RD)) u_rd (
        .sel_n(rd_sel_n), .src(rd_src), .rd_en(rd_en), .bus_en(bus_en),
        .drive(drive), .rdata(rdata)
    );

    // tri-state bus driver
    assign data_io = drive ? rdata : {DATA_W{1'bz}};

    // exported fields
    assign own_addr  = adr_q[DATA_W-1:1];
    assign gc_en     = adr_q[0];
    assign irq       = ctl_q[CB_SI];
    assign ena       = ctl_q[CB_ENA];
    assign start_req = ctl_q[CB_STA];
    assign stop_req  = ctl_q[CB_STO];
    assign ack_en    = ctl_q[CB_ACK];
    assign baud_sel  = {ctl_q[CB_CR2], ctl_q[CB_CR1], ctl_q[CB_CR0]};
    assign baud_mix  = ctl_q[CB_CR1] | ~ctl_q[CB_CR0];
endmodule

// File: rtl/i2c_host_regs_chk.sv
// Module: property checker for the host register block, bound to the top.
// Assumes sampling on the same falling edge that updates the registers.
module i2c_host_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] rd_sel_n,
    input logic [2:0] wr_sel_n,
    input logic       rd_en,
    input logic       bus_en,
    input logic       clr_en,
    input logic [7:0] data_io,
    input logic       irq,
    input logic       eng_si_set,
    input logic       eng_sto_clr,
    input logic       stop_req,
    input logic [6:0] own_addr,
    input logic       gc_en
);
    logic wr_ok;
    assign wr_ok = !rd_en && !bus_en;

    // R4: an engine set raises the request on the next edge
    p_si_set_r4: assert property (@(negedge clk) disable iff (!rst_n)
        eng_si_set |=> irq);

    // R5: without a permitted host clear, the flag persists
    p_si_keep_r5: assert property (@(negedge clk) disable iff (!rst_n)
        (irq && !(wr_ok && !wr_sel_n[0] && clr_en)) |=> irq);

    // R5: only the engine can raise the flag
    p_si_noset_r5: assert property (@(negedge clk) disable iff (!rst_n)
        (!irq && !eng_si_set) |=> !irq);

    // R6: status low bits read zero
    p_stat_low_r6: assert property (@(negedge clk) disable iff (!rst_n)
        (rd_en && bus_en && rd_sel_n == 5'b10111) |-> data_io[2:0] == 3'b000);

    // R7: an address write appears on the exported fields
    p_adr_out_r7: assert property (@(negedge clk) disable iff (!rst_n)
        (wr_ok && !wr_sel_n[2]) |=> {own_addr, gc_en} == $past(data_io));

    // R8: an engine stop clear without a host control write drops the bit
    p_sto_clr_r8: assert property (@(negedge clk) disable iff (!rst_n)
        (eng_sto_clr && !(wr_ok && !wr_sel_n[0])) |=> !stop_req);
endmodule

bind i2c_host_regs i2c_host_regs_chk u_chk (.*);

// File: tb/i2c_host_regs_tb.sv
// Scoreboard bench: driver tasks queue expected items, a monitor pops them.
module i2c_host_regs_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] rd_sel_n = 5'h1F;
    logic [2:0] wr_sel_n = 3'h7;
    logic       rd_en = 1'b1, bus_en = 1'b1, clr_en = 1'b0;
    logic [7:0] tb_d = '0;
    logic       tb_drv = 1'b0;
    wire  [7:0] data_bus;
    logic       irq;
    logic       eng_stat_ld = 0, eng_si_set = 0, eng_dat_ld = 0, eng_sto_clr = 0;
    logic [4:0] eng_stat_code = '0;
    logic [7:0] eng_dat_in = '0, eng_ist = '0;
    logic [6:0] own_addr;
    logic       gc_en, ena, start_req, stop_req, ack_en, baud_mix;
    logic [7:0] dat_q;
    logic [2:0] baud_sel;

    int checks = 0, fails = 0;
    bit done = 0;

    typedef struct { int kind; logic [7:0] exp; string tag; } item_t;
    item_t sb[$];

    assign data_bus = tb_drv ? tb_d : 8'bz;

    always #4 clk = ~clk;   // 125 MHz

    i2c_host_regs u_dut (
        .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
        .rd_en(rd_en), .bus_en(bus_en), .clr_en(clr_en), .data_io(data_bus),
        .irq(irq), .eng_stat_ld(eng_stat_ld), .eng_stat_code(eng_stat_code),
        .eng_si_set(eng_si_set), .eng_dat_ld(eng_dat_ld), .eng_dat_in(eng_dat_in),
        .eng_sto_clr(eng_sto_clr), .eng_ist(eng_ist), .own_addr(own_addr),
        .gc_en(gc_en), .dat_q(dat_q), .ena(ena), .start_req(start_req),
        .stop_req(stop_req), .ack_en(ack_en), .baud_sel(baud_sel), .baud_mix(baud_mix)
    );

    // monitor: sample 3 ns after each rising edge, away from the falling edge
    initial begin
        forever begin
            @(posedge clk);
            #3;
            while (sb.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb.pop_front();
                case (it.kind)
                    0: act = data_bus;
                    1: act = {7'b0, irq};
                    2: act = {own_addr, gc_en};
                    3: act = {4'b0, baud_sel, baud_mix};
                    4: act = {7'b0, stop_req};
                    5: act = dat_q;
                    default: act = {5'b0, ena, start_req, ack_en};
                endcase
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic expect_now(input int kind, input logic [7:0] exp, input string tag);
        item_t it;
        @(posedge clk); #1;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic rd(input logic [4:0] sel, input logic [7:0] exp, input string tag);
        item_t it;
        @(posedge clk); #1;
        rd_sel_n = sel; rd_en = 1; bus_en = 1;
        it.kind = 0; it.exp = exp; it.tag = tag;
        sb.push_back(it);
        @(posedge clk); #1;
        rd_sel_n = 5'h1F;
    endtask

    // one falling edge of combined host and engine stimulus
    task automatic step(input logic [2:0] wn, input logic [7:0] wd, input logic clr,
                        input logic blk, input logic si, input logic sl,
                        input logic [4:0] code, input logic dl,
                        input logic [7:0] dd, input logic sc);
        @(posedge clk); #1;
        wr_sel_n = wn; rd_en = blk; bus_en = 0; tb_drv = (wn != 3'h7); tb_d = wd;
        clr_en = clr; eng_si_set = si; eng_stat_ld = sl; eng_stat_code = code;
        eng_dat_ld = dl; eng_dat_in = dd; eng_sto_clr = sc;
        @(posedge clk); #1;
        wr_sel_n = 3'h7; rd_en = 1; bus_en = 1; tb_drv = 0; clr_en = 0;
        eng_si_set = 0; eng_stat_ld = 0; eng_dat_ld = 0; eng_sto_clr = 0;
    endtask

    task automatic wr(input logic [2:0] wn, input logic [7:0] wd, input logic clr);
        step(wn, wd, clr, 0, 0, 0, '0, 0, '0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset values
        rd(5'b10111, 8'hF8, "R1 status after reset");
        rd(5'b11110, 8'h00, "R1 control after reset");
        rd(5'b11011, 8'h00, "R1 address after reset");
        rd(5'b11101, 8'h00, "R1 data after reset");
        expect_now(1, 8'h00, "R1 irq after reset");
        // R2, R7 address write and layout
        wr(3'b011, 8'hA5, 0);
        rd(5'b11011, 8'hA5, "R2 address readback");
        expect_now(2, 8'hA5, "R7 own_addr/gc_en fields");
        // R9 control layout and helper
        wr(3'b110, 8'h83, 0);
        expect_now(3, 8'h0F, "R9 baud bits 111 mix 1");
        rd(5'b11110, 8'h83, "R9 control readback");
        wr(3'b110, 8'h01, 0);
        expect_now(3, 8'h02, "R9 baud 001 mix 0");
        wr(3'b110, 8'h64, 0);
        expect_now(6, 8'h07, "R9 enable/start/ack bits");
        // R2 multiple selects and blocked write
        wr(3'b001, 8'h3C, 0);
        rd(5'b11011, 8'h3C, "R2 multi-write address");
        rd(5'b11101, 8'h3C, "R2 multi-write data");
        step(3'b101, 8'h77, 0, 1, 0, 0, '0, 0, '0, 0);
        rd(5'b11101, 8'h3C, "R2 write ignored with rd_en high");
        // R4 engine sets flag
        step(3'h7, 8'h00, 0, 0, 1, 0, '0, 0, '0, 0);
        expect_now(1, 8'h01, "R4 irq after engine set");
        rd(5'b11110, 8'h6C, "R4 flag visible in control");
        // R5 clear rules
        wr(3'b110, 8'h64, 0);
        expect_now(1, 8'h01, "R5 clear blocked without clr_en");
        wr(3'b110, 8'h64, 1);
        expect_now(1, 8'h00, "R5 clear with clr_en");
        wr(3'b110, 8'h6C, 1);
        expect_now(1, 8'h00, "R5 host cannot set flag");
        // R10 simultaneous set and clear
        step(3'b110, 8'h64, 1, 0, 1, 0, '0, 0, '0, 0);
        expect_now(1, 8'h01, "R10 engine set beats host clear");
        wr(3'b110, 8'h64, 1);
        // R6 status codes
        step(3'h7, 8'h00, 0, 0, 0, 1, 5'h03, 0, '0, 0);
        rd(5'b10111, 8'h18, "R6 status code 03");
        step(3'h7, 8'h00, 0, 0, 0, 1, 5'h11, 0, '0, 0);
        rd(5'b10111, 8'h88, "R6 status code 11");
        // R8 stop bit
        wr(3'b110, 8'h74, 0);
        expect_now(4, 8'h01, "R8 stop set by host");
        step(3'h7, 8'h00, 0, 0, 0, 0, '0, 0, '0, 1);
        expect_now(4, 8'h00, "R8 stop cleared by engine");
        step(3'b110, 8'h74, 0, 0, 0, 0, '0, 0, '0, 1);
        expect_now(4, 8'h01, "R8 host write beats engine clear");
        // R11 data collision and output
        step(3'b101, 8'h11, 0, 0, 0, 0, '0, 1, 8'h96, 0);
        rd(5'b11101, 8'h96, "R11 engine load wins");
        wr(3'b101, 8'h5A, 0);
        expect_now(5, 8'h5A, "R11 dat_q after host write");
        // R3 internal status read
        eng_ist = 8'hC3;
        rd(5'b01111, 8'hC3, "R3 internal status read");
        repeat (2) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule